// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit performs bit-field operations whose position and width are chosen per operation, on a base operand held in a register pair. The base arrives as a 64-bit window (the named register in the low half, its successor in the high half), so a field that starts near the top of the first register may continue into the next one.

Three operations are offered. A signed extract returns the selected field sign-extended to 32 bits. An unsigned extract returns it zero-extended. An insert overwrites the field in the window with the low bits of a source word, and returns the whole updated pair for write-back. Extracts also produce negative, zero, overflow and carry flags. A field descriptor that a register-resident operand cannot hold raises a reserved-operand fault. On a fault the window goes out unmodified and the flags keep their old values.

Each operation is accepted on a one-cycle strobe. All of its results appear together on the next cycle, marked by a done strobe, and stay on the outputs until the next accepted operation.

Top module: `bfx_unit`

## Requirements
- R1: Operation code 2'b00 (signed extract) returns the `size` bits starting at bit `pos` of the window, with bit `size-1` of the field copied into all higher result bits up to bit 31.
- R2: Operation code 2'b01 (unsigned extract) returns the same field with all result bits at and above `size` cleared. Code 2'b11 behaves exactly like 2'b01.
- R3: When `size` is 0 and no fault is raised, an extract returns 0 and an insert returns the window unchanged. `size` 0 never faults, whatever the value of `pos`.
- R4: After a non-faulting extract, flag N equals result bit 31, flag Z is 1 exactly when the result is 0, and flags V and C are 0.
- R5: Operation code 2'b10 (insert) replaces window bits `pos`..`pos+size-1` with source bits `size-1`..0. It leaves every other window bit unchanged, including fields that reach bits 32..63, and returns a result of 0.
- R6: A fault is raised when `size` is greater than 32, compared as unsigned.
- R7: A fault is raised when `size` is nonzero and `pos` is greater than 31, compared as unsigned.
- R8: On a fault the window goes out equal to the window presented, the result is 0, and flags N, Z, V and C keep their previous values.
- R9: An insert, with or without a fault, leaves all four flags unchanged.
- R10: `done` is high exactly in the cycle after an accepted `op_valid`. The outputs hold their values until the next accepted operation. After reset, `done`, `fault`, the result, the window output and the flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accept the operation on the current inputs |
| op_kind | input | 2 | 00 signed extract, 01/11 unsigned extract, 10 insert |
| fld_pos | input | 32 | Field start bit within the window (unsigned) |
| fld_size | input | 8 | Field width in bits (unsigned) |
| base_in | input | 64 | Register pair: named register in [31:0], successor in [63:32] |
| src_in | input | 32 | Insert source data |
| done | output | 1 | Results valid for the operation of the previous cycle |
| result | output | 32 | Extracted value, 0 for inserts and faults |
| base_out | output | 64 | Updated register pair for write-back |
| fault | output | 1 | Reserved-operand fault for the operation |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Every result of this unit (result, window, fault and flags) is registered once, so each is due exactly one cycle after the accepting clock edge. The bench drives an operation on a falling edge, lets one rising edge capture it, and reads all outputs at the next falling edge, when `done` must be high. It then checks that `done` drops one cycle later while the outputs hold. Flag checks use a value that the bench keeps up to date from its own model over the whole sequence, so a hold after a fault or an insert is compared against the flags of the last valid extract.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
   typedef enum logic [1:0] {
      BFX_SEXT = 2'b00,
      BFX_ZEXT = 2'b01,
      BFX_INS  = 2'b10,
      BFX_ZALT = 2'b11
   } bfx_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } bfx_flags_t;
endpackage

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen #(
   parameter int DATA_W = 32,
   parameter int SIZE_W = 8
) (
   input  logic [SIZE_W-1:0] size_i,
   output logic [DATA_W-1:0] mask_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign mask_o[i] = ({{(32-SIZE_W){1'b0}}, size_i} > 32'(i));
   end
endmodule

// File: rtl/bfx_shifter.sv
module bfx_shifter #(
   parameter int WIN_W  = 64,
   parameter int OFS_W  = 5,
   parameter int IMPL   = 1
) (
   input  logic [WIN_W-1:0] win_i,
   input  logic [OFS_W-1:0] ofs_i,
   output logic [WIN_W-1:0] win_o
);
   initial begin
      if (IMPL != 0 && IMPL != 1)
         $error("bfx_shifter: IMPL must be 0 or 1");
   end

   if (IMPL == 0) begin : g_op
      assign win_o = win_i >> ofs_i;
   end else begin : g_log
      logic [WIN_W-1:0] stage [OFS_W+1];
      assign stage[0] = win_i;
      for (genvar s = 0; s < OFS_W; s++) begin : g_stage
         assign stage[s+1] = ofs_i[s] ? (stage[s] >> (1 << s)) : stage[s];
      end
      assign win_o = stage[OFS_W];
   end
endmodule

// File: rtl/bfx_legal.sv
module bfx_legal #(
   parameter int DATA_W = 32,
   parameter int POS_W  = 32,
   parameter int SIZE_W = 8
) (
   input  logic [POS_W-1:0]  pos_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic              fault_o
);
   logic too_wide;
   logic bad_pos;

   assign too_wide = ({{(32-SIZE_W){1'b0}}, size_i} > 32'(DATA_W));
   assign bad_pos  = (size_i != '0) && (pos_i > POS_W'(DATA_W - 1));
   assign fault_o  = too_wide | bad_pos;
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
   import bfx_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int POS_W      = 32,
   parameter int SIZE_W     = 8,
   parameter int SHIFT_IMPL = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  op_valid,
   input  logic [1:0]            op_kind,
   input  logic [POS_W-1:0]      fld_pos,
   input  logic [SIZE_W-1:0]     fld_size,
   input  logic [2*DATA_W-1:0]   base_in,
   input  logic [DATA_W-1:0]     src_in,
   output logic                  done,
   output logic [DATA_W-1:0]     result,
   output logic [2*DATA_W-1:0]   base_out,
   output logic                  fault,
   output logic                  flag_n,
   output logic                  flag_z,
   output logic                  flag_v,
   output logic                  flag_c
);
   localparam int WIN_W = 2 * DATA_W;
   localparam int OFS_W = $clog2(DATA_W);

   initial begin
      if (DATA_W < 2 || (1 << OFS_W) != DATA_W)
         $error("bfx_unit: DATA_W must be a power of two");
      if (SIZE_W > 31 || (1 << SIZE_W) <= DATA_W)
         $error("bfx_unit: SIZE_W too narrow for DATA_W");
      if (POS_W <= OFS_W || POS_W > 32)
         $error("bfx_unit: POS_W out of range");
   end

   // ---------------- combinational datapath ----------------
   bfx_op_e               kind;
   logic [OFS_W-1:0]      ofs;
   logic [DATA_W-1:0]     mask;
   logic [WIN_W-1:0]      win_sh;
   logic [DATA_W-1:0]     fld;
   logic [OFS_W-1:0]      top_idx;
   logic                  sgn;
   logic [DATA_W-1:0]     ext_val;
   logic [WIN_W-1:0]      ins_mask;
   logic [WIN_W-1:0]      ins_data;
   logic [WIN_W-1:0]      ins_win;
   logic                  bad;
   logic                  is_ins;

   assign kind   = bfx_op_e'(op_kind);
   assign is_ins = (kind == BFX_INS);
   assign ofs    = fld_pos[OFS_W-1:0];

   bfx_mask_gen #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) mask_i (
      .size_i (fld_size),
      .mask_o (mask)
   );

   bfx_shifter #(.WIN_W(WIN_W), .OFS_W(OFS_W), .IMPL(SHIFT_IMPL)) shift_i (
      .win_i  (base_in),
      .ofs_i  (ofs),
      .win_o  (win_sh)
   );

   bfx_legal #(.DATA_W(DATA_W), .POS_W(POS_W), .SIZE_W(SIZE_W)) legal_i (
      .pos_i   (fld_pos),
      .size_i  (fld_size),
      .fault_o (bad)
   );

   assign fld     = win_sh[DATA_W-1:0] & mask;
   assign top_idx = fld_size[OFS_W-1:0] - OFS_W'(1);
   assign sgn     = win_sh[top_idx] && (fld_size != '0);

   always_comb begin
      ext_val = fld;
      if (kind == BFX_SEXT && sgn)
         ext_val = fld | ~mask;
   end

   assign ins_mask = {{DATA_W{1'b0}}, mask} << ofs;
   assign ins_data = {{DATA_W{1'b0}}, src_in & mask} << ofs;
   assign ins_win  = (base_in & ~ins_mask) | ins_data;

   // ---------------- result registers ----------------
   bfx_flags_t flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         result   <= '0;
         base_out <= '0;
         fault    <= 1'b0;
         flags_q  <= '0;
      end else begin
         done <= op_valid;
         if (op_valid) begin
            fault <= bad;
            if (bad) begin
               result   <= '0;
               base_out <= base_in;
            end else if (is_ins) begin
               result   <= '0;
               base_out <= ins_win;
            end else begin
               result    <= ext_val;
               base_out  <= base_in;
               flags_q.n <= ext_val[DATA_W-1];
               flags_q.z <= (ext_val == '0);
               flags_q.v <= 1'b0;
               flags_q.c <= 1'b0;
            end
         end
      end
   end

   assign flag_n = flags_q.n;
   assign flag_z = flags_q.z;
   assign flag_v = flags_q.v;
   assign flag_c = flags_q.c;

   // ---------------- assertions ----------------
   a_r10_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> done);

   a_r10_done_only_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !done);

   a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(result) && $stable(base_out) && $stable(fault)));

   a_r8_fault_keeps_window: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && bad |=> (base_out == $past(base_in)) && (result == '0));

   a_r8_fault_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && bad |=> $stable({flag_n, flag_z, flag_v, flag_c}));

   a_r9_insert_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && is_ins |=> $stable({flag_n, flag_z, flag_v, flag_c}));

   a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !bad && !is_ins |=> (flag_z == (result == '0)) && !flag_v && !flag_c);

   a_r3_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && fld_size == '0 |=> !fault && (result == '0) && (base_out == $past(base_in)));
endmodule

// File: tb/bfx_unit_tb_top.sv
module bfx_unit_tb_top;
   typedef struct packed {
      logic [1:0]  kind;
      logic [31:0] pos;
      logic [7:0]  size;
      logic [63:0] base;
      logic [31:0] src;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 32'd4,  8'd10, 64'h0000_0000_0000_2A50, 32'h0},
      '{2'b01, 32'd4,  8'd10, 64'h0000_0000_0000_2A50, 32'h0},
      '{2'b00, 32'd8,  8'd8,  64'h0000_0000_0000_F300, 32'h0},
      '{2'b01, 32'd0,  8'd32, 64'h1111_1111_8765_4321, 32'h0},
      '{2'b00, 32'd31, 8'd32, 64'h0000_0001_8000_0000, 32'h0},
      '{2'b10, 32'd28, 8'd8,  64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0015},
      '{2'b10, 32'd3,  8'd0,  64'h0123_4567_89AB_CDEF, 32'hFFFF_FFFF},
      '{2'b00, 32'd40, 8'd0,  64'hFFFF_FFFF_FFFF_FFFF, 32'h0},
      '{2'b00, 32'd0,  8'd33, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0},
      '{2'b10, 32'd32, 8'd1,  64'h0000_0000_0000_0000, 32'h1},
      '{2'b11, 32'd12, 8'd4,  64'h0000_0000_0000_F000, 32'h0},
      '{2'b00, 32'd17, 8'd1,  64'h0000_0000_0002_0000, 32'h0},
      '{2'b10, 32'd31, 8'd32, 64'h0000_0000_0000_0000, 32'hDEAD_BEEF},
      '{2'b01, 32'd60, 8'd4,  64'hFFFF_FFFF_FFFF_FFFF, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_kind = '0;
   logic [31:0] fld_pos = '0;
   logic [7:0]  fld_size = '0;
   logic [63:0] base_in = '0;
   logic [31:0] src_in = '0;
   logic        done, fault, flag_n, flag_z, flag_v, flag_c;
   logic [31:0] result;
   logic [63:0] base_out;

   int n_checks = 0;
   int n_fail = 0;
   logic m_n = 1'b0, m_z = 1'b0;

   always #2.5 clk = ~clk;

   bfx_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .fld_pos(fld_pos), .fld_size(fld_size), .base_in(base_in), .src_in(src_in),
      .done(done), .result(result), .base_out(base_out), .fault(fault),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // reference model written from the requirements, bit by bit
   task automatic model(input vec_t v, output logic [31:0] res,
                        output logic [63:0] nb, output logic flt);
      int sz = int'(v.size);
      flt = (v.size > 8'd32) || (v.size != 0 && v.pos > 32'd31);
      res = '0;
      nb  = v.base;
      if (!flt && sz != 0) begin
         int p = int'(v.pos);
         if (v.kind == 2'b10) begin
            for (int i = 0; i < sz; i++) nb[p+i] = v.src[i];
         end else begin
            for (int i = 0; i < 32; i++) begin
               if (i < sz) res[i] = v.base[p+i];
               else res[i] = (v.kind == 2'b00) ? v.base[p+sz-1] : 1'b0;
            end
         end
      end
   endtask

   task automatic run(input vec_t v);
      logic [31:0] e_res;
      logic [63:0] e_base;
      logic        e_flt;
      string       rtag, btag, ftag, ctag;
      model(v, e_res, e_base, e_flt);
      rtag = (v.kind == 2'b00) ? "R1" : (v.kind == 2'b10) ? "R5" : "R2";
      if (v.size == 0) rtag = "R3";
      if (e_flt) rtag = "R8";
      btag = e_flt ? "R8" : (v.size == 0) ? "R3" : "R5";
      ftag = (v.size > 8'd32) ? "R6" : "R7";
      ctag = e_flt ? "R8" : (v.kind == 2'b10) ? "R9" : "R4";
      if (!e_flt && v.kind != 2'b10) begin
         m_n = e_res[31];
         m_z = (e_res == 0);
      end
      @(negedge clk);
      op_valid = 1'b1; op_kind = v.kind; fld_pos = v.pos; fld_size = v.size;
      base_in = v.base; src_in = v.src;
      @(negedge clk);
      op_valid = 1'b0;
      base_in = ~v.base;
      check(done == 1'b1, "R10 done", 64'(done), 64'd1);
      check(result == e_res, rtag, 64'(result), 64'(e_res));
      check(base_out == e_base, btag, base_out, e_base);
      check(fault == e_flt, ftag, 64'(fault), 64'(e_flt));
      check({flag_n, flag_z, flag_v, flag_c} == {m_n, m_z, 2'b00}, ctag,
            64'({flag_n, flag_z, flag_v, flag_c}), 64'({m_n, m_z, 2'b00}));
      @(negedge clk);
      check(done == 1'b0 && result == e_res && base_out == e_base, "R10 hold",
            {31'd0, done, result}, {32'd0, e_res});
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R10: watchdog expired, actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(done == 0 && fault == 0 && result == 0 && base_out == 0, "R10 reset",
            {30'd0, done, fault, result}, 64'd0);
      check({flag_n, flag_z, flag_v, flag_c} == 4'b0, "R10 reset flags",
            64'({flag_n, flag_z, flag_v, flag_c}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R10 idle", 64'(done), 64'd0);

      for (int k = 0; k < NV; k++) run(VECS[k]);

      // directed: hand-worked values
      run('{2'b00, 32'd4, 8'd10, 64'h0000_0000_0000_2A50, 32'h0});
      check(result == 32'hFFFF_FEA5, "R1 directed", 64'(result), 64'hFFFF_FEA5);
      run('{2'b10, 32'd28, 8'd8, 64'h0, 32'h0000_00A5});
      check(base_out == 64'h0000_000A_5000_0000, "R5 directed cross", base_out,
            64'h0000_000A_5000_0000);
      // flags after a fault following an extract with N=1: hold
      run('{2'b00, 32'd0, 8'd4, 64'h8, 32'h0});
      run('{2'b01, 32'd33, 8'd2, 64'h0, 32'h0});
      check(flag_n == 1'b1 && flag_z == 1'b0, "R8 flags held", 64'({flag_n, flag_z}),
            64'd2);
      run('{2'b10, 32'd0, 8'd4, 64'h0, 32'h0});
      check(flag_n == 1'b1 && flag_z == 1'b0, "R9 flags held", 64'({flag_n, flag_z}),
            64'd2);
      run('{2'b11, 32'd0, 8'd8, 64'h80, 32'h0});
      check(result == 32'h80 && flag_n == 1'b0, "R2 code 11", 64'(result), 64'h80);
      run('{2'b01, 32'd31, 8'd33, 64'h0, 32'h0});
      check(fault == 1'b1, "R6 size 33", 64'(fault), 64'd1);
      run('{2'b00, 32'hFFFF_FFFF, 8'd0, 64'h0, 32'h0});
      check(fault == 1'b0 && result == 0, "R3 R7 size zero big pos", 64'(fault), 64'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule